// File: doc/BRIEF.md
# Biphase Serial Word Receiver

This block takes one oversampled serial line that carries a mid-bit-transition (biphase) code and turns each single-word frame on it into a parallel word. In every bit period the line shows the complement of the bit during the first half and the true value during the second half. The bit value is therefore the line level just after the mid-bit edge. The system clock runs at a fixed multiple `PER_BIT` of the bit rate. The receiver recovers bit timing from the line edges alone.

A frame opens with a run of half-bit alternation (one-bits). The line then stays low for one and a half bit times and high for one and a half bit times. A sync bit of value 1 follows, then a `WORD_W`-bit word sent most significant bit first and one parity bit. The frame closes with a 0 bit, a high level of about one bit time, and a return to low. A good frame produces a one-cycle strobe with the word. A malformed frame puts the receiver into a sticky fault state and places a fault code on the same word bus. Only a synchronous reset clears the fault.

Top module: `bphs_rx`

## Requirements
- R1: A well-formed frame produces exactly one `valid_o` pulse. In that cycle `word_o` equals the transmitted word, whose first transmitted bit lands in `word_o[WORD_W-1]`. `err_o` stays 0.
- R2: `valid_o` is never high for two cycles in a row. It rises only after the closing high level of a good frame has returned low.
- R3: The receiver starts a frame only when it sees at least `PRE_RUNS` (default 8) consecutive half-bit runs, then a low run and a high run of 1.5 bit times each. Four one-bits sent from an idle-low line give 7 such runs and start nothing.
- R4: The following leave the receiver idle, with no fault and no strobe: a steady high or low line, a start pattern whose wide high lasts far too long, and a long low where the sync bit should be.
- R5: A missing mid-bit edge during a data bit, the parity bit or the closing 0 bit sets `err_o`. `word_o` then shows code 1. A missing edge during the sync bit only returns the receiver to idle, without a fault.
- R6: Parity is even across the sync bit, the data bits and the parity bit. A word with six ones is accepted with parity bit 1. A wrong parity bit gives code 2 as soon as that bit is decoded.
- R7: After the parity bit, a closing bit of value 1 gives code 3. A closing 0 bit followed by no high level gives code 3. A closing high level that lasts only half a bit also gives code 3.
- R8: Once `err_o` is high it stays high, `word_o` keeps the fault code and `valid_o` stays low, even if good frames arrive later.
- R9: A synchronous reset drives `err_o`, `valid_o` and `word_o` to 0. After reset the next good frame is received.
- R10: A mid-bit edge is accepted anywhere between 3/4 and 5/4 bit periods after the previous mid-bit edge. Frames whose bit periods alternate between 7 and 9 clocks (at `PER_BIT` = 8) decode correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, `PER_BIT` times the bit rate |
| rst | input | 1 | Synchronous active-high reset, clears the fault |
| rx_i | input | 1 | Asynchronous serial line |
| word_o | output | WORD_W | Last received word, or the fault code while `err_o` is high |
| valid_o | output | 1 | One-cycle strobe marking a newly received word |
| err_o | output | 1 | Sticky fault flag |

## Verification
Good frames carry words with six, two, ten and five ones. This separates an accepted parity bit of 1 from one of 0 and exposes a wrong bit order. A frame sent with alternating 7- and 9-clock bit periods shows whether the edge window tracks real jitter or only nominal timing. Truncated and malformed frames are cut at the sync bit, mid-word, at parity, in the closing bit and in the closing pulse. Each one shows whether the receiver goes back to idle or picks the right fault code. A good frame sent after a fault, and again after reset, tells the sticky fault state apart from a clean restart.

// File: rtl/bphs_pkg.sv
package bphs_pkg;

    // coarse length class of one constant-level run on the line
    typedef enum logic [1:0] {
        RC_SHORT,    // about half a bit
        RC_ONE,      // about one bit
        RC_ONEHALF,  // about one and a half bits
        RC_LONG      // longer than any legal run
    } run_cls_e;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_WIDE_HI,
        ST_SYNC,
        ST_BITS,
        ST_END_LO,
        ST_END_HI,
        ST_ERR
    } rx_state_e;

    typedef struct packed {
        logic     lvl;      // synchronized line level
        logic     toggled;  // level differs from previous cycle
        run_cls_e cls;      // class of the run counted so far
    } line_ev_t;

    localparam int unsigned FAULT_MIDBIT = 1;
    localparam int unsigned FAULT_PARITY = 2;
    localparam int unsigned FAULT_ENDSEQ = 3;

    // boundaries sit at 3/4, 5/4 and 7/4 of a bit period
    function automatic run_cls_e classify_run(input int unsigned len,
                                              input int unsigned per_bit);
        if (len * 4 < 3 * per_bit)      return RC_SHORT;
        else if (len * 4 < 5 * per_bit) return RC_ONE;
        else if (len * 4 < 7 * per_bit) return RC_ONEHALF;
        else                            return RC_LONG;
    endfunction

endpackage

// File: rtl/bphs_line_front.sv
module bphs_line_front
    import bphs_pkg::*;
#(
    parameter int unsigned PER_BIT = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     rx_i,
    output line_ev_t ev_o
);
    localparam int unsigned RUN_MAX = 2 * PER_BIT;
    localparam int unsigned RUN_W   = $clog2(RUN_MAX + 1);

    // pipe[0], pipe[1]: two-flop synchronizer; pipe[2]: previous level
    logic [2:0]       pipe;
    logic [RUN_W-1:0] run_q;
    logic             flip;

    assign flip = pipe[1] ^ pipe[2];

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe  <= '0;
            run_q <= '0;
        end else begin
            pipe <= {pipe[1:0], rx_i};
            if (flip)
                run_q <= RUN_W'(1);
            else if (run_q < RUN_W'(RUN_MAX))
                run_q <= run_q + 1'b1;
        end
    end

    always_comb begin
        ev_o.lvl     = pipe[1];
        ev_o.toggled = flip;
        ev_o.cls     = classify_run(32'(run_q), PER_BIT);
    end

endmodule

// File: rtl/bphs_phase_track.sv
module bphs_phase_track #(
    parameter int unsigned PER_BIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic arm_i,
    input  logic toggled_i,
    output logic mid_hit_o,
    output logic mid_miss_o
);
    localparam int unsigned QTR    = PER_BIT / 4;
    localparam int unsigned WIN_LO = PER_BIT - QTR;
    localparam int unsigned WIN_HI = PER_BIT + QTR;
    localparam int unsigned PH_W   = $clog2(WIN_HI + 2);

    logic [PH_W-1:0] ph_q;
    logic            in_win;

    assign in_win     = (ph_q >= PH_W'(WIN_LO)) && (ph_q <= PH_W'(WIN_HI));
    assign mid_hit_o  = en_i && toggled_i && in_win;
    assign mid_miss_o = en_i && !toggled_i && (ph_q >= PH_W'(WIN_HI));

    // cycles since the last accepted mid-bit edge; early edges are bit boundaries
    always_ff @(posedge clk) begin
        if (rst)
            ph_q <= '0;
        else if (arm_i || mid_hit_o)
            ph_q <= PH_W'(1);
        else if (ph_q < PH_W'(WIN_HI + 1))
            ph_q <= ph_q + 1'b1;
    end

endmodule

// File: rtl/bphs_frame_ctl.sv
module bphs_frame_ctl
    import bphs_pkg::*;
#(
    parameter int unsigned WORD_W   = 10,
    parameter int unsigned PRE_RUNS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  line_ev_t          ev_i,
    input  logic              mid_hit_i,
    input  logic              mid_miss_i,
    output logic              bits_en_o,
    output logic              arm_o,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o,
    output logic              err_o
);
    localparam int unsigned POS_PAR = WORD_W;
    localparam int unsigned POS_END = WORD_W + 1;
    localparam int unsigned POS_W   = $clog2(WORD_W + 2);
    localparam int unsigned SH_W    = $clog2(PRE_RUNS + 1);

    rx_state_e         st_q;
    logic [SH_W-1:0]   sh_q;
    logic [POS_W-1:0]  pos_q;
    logic [WORD_W-1:0] sr_q, word_q;
    logic              par_q, valid_q, err_q;
    logic              rising;
    logic              fault_now;
    logic [WORD_W-1:0] fault_code;

    assign rising    = ev_i.toggled && ev_i.lvl;
    assign bits_en_o = (st_q == ST_BITS);
    assign arm_o     = (st_q == ST_SYNC) && rising && (ev_i.cls == RC_SHORT);

    always_comb begin
        fault_now  = 1'b0;
        fault_code = WORD_W'(FAULT_MIDBIT);
        case (st_q)
            ST_BITS: begin
                if (mid_miss_i) begin
                    fault_now  = 1'b1;
                    fault_code = WORD_W'(FAULT_MIDBIT);
                end else if (mid_hit_i && pos_q == POS_W'(POS_PAR) && (par_q ^ ev_i.lvl)) begin
                    fault_now  = 1'b1;
                    fault_code = WORD_W'(FAULT_PARITY);
                end else if (mid_hit_i && pos_q == POS_W'(POS_END) && ev_i.lvl) begin
                    fault_now  = 1'b1;
                    fault_code = WORD_W'(FAULT_ENDSEQ);
                end
            end
            ST_END_LO: begin
                if (ev_i.cls != RC_SHORT) begin
                    fault_now  = 1'b1;
                    fault_code = WORD_W'(FAULT_ENDSEQ);
                end
            end
            ST_END_HI: begin
                if (ev_i.toggled ? (ev_i.cls != RC_ONE)
                                 : (ev_i.cls == RC_ONEHALF || ev_i.cls == RC_LONG)) begin
                    fault_now  = 1'b1;
                    fault_code = WORD_W'(FAULT_ENDSEQ);
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_HUNT;
            sh_q    <= '0;
            pos_q   <= '0;
            sr_q    <= '0;
            word_q  <= '0;
            par_q   <= 1'b1;
            valid_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (st_q != ST_HUNT)
                sh_q <= '0;
            if (fault_now) begin
                st_q   <= ST_ERR;
                err_q  <= 1'b1;
                word_q <= fault_code;
            end else begin
                case (st_q)
                    ST_HUNT: if (ev_i.toggled) begin
                        if (ev_i.cls == RC_SHORT) begin
                            if (sh_q < SH_W'(PRE_RUNS))
                                sh_q <= sh_q + 1'b1;
                        end else begin
                            sh_q <= '0;
                            if (rising && ev_i.cls == RC_ONEHALF && sh_q == SH_W'(PRE_RUNS))
                                st_q <= ST_WIDE_HI;
                        end
                    end
                    ST_WIDE_HI: begin
                        if (ev_i.toggled)
                            st_q <= (ev_i.cls == RC_ONEHALF) ? ST_SYNC : ST_HUNT;
                        else if (ev_i.cls == RC_LONG)
                            st_q <= ST_HUNT;
                    end
                    ST_SYNC: begin
                        if (arm_o) begin
                            st_q  <= ST_BITS;
                            pos_q <= '0;
                            sr_q  <= '0;
                            par_q <= 1'b1;  // sync bit counts as a one
                        end else if (ev_i.toggled || ev_i.cls == RC_LONG) begin
                            st_q <= ST_HUNT;
                        end
                    end
                    ST_BITS: if (mid_hit_i) begin
                        if (pos_q < POS_W'(POS_PAR)) begin
                            sr_q  <= {sr_q[WORD_W-2:0], ev_i.lvl};
                            par_q <= par_q ^ ev_i.lvl;
                            pos_q <= pos_q + 1'b1;
                        end else if (pos_q == POS_W'(POS_PAR)) begin
                            pos_q <= pos_q + 1'b1;
                        end else begin
                            st_q <= ST_END_LO;
                        end
                    end
                    ST_END_LO: if (ev_i.toggled) st_q <= ST_END_HI;
                    ST_END_HI: if (ev_i.toggled) begin
                        word_q  <= sr_q;
                        valid_q <= 1'b1;
                        st_q    <= ST_HUNT;
                    end
                    ST_ERR: ;
                    default: st_q <= ST_HUNT;
                endcase
            end
        end
    end

    assign word_o  = word_q;
    assign valid_o = valid_q;
    assign err_o   = err_q;

endmodule

// File: rtl/bphs_rx.sv
module bphs_rx
    import bphs_pkg::*;
#(
    parameter int unsigned PER_BIT  = 8,
    parameter int unsigned WORD_W   = 10,
    parameter int unsigned PRE_RUNS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_i,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o,
    output logic              err_o
);
    line_ev_t ev;
    logic     bits_en, arm, mid_hit, mid_miss;

    bphs_line_front #(.PER_BIT(PER_BIT)) u_front (
        .clk  (clk),
        .rst  (rst),
        .rx_i (rx_i),
        .ev_o (ev)
    );

    bphs_phase_track #(.PER_BIT(PER_BIT)) u_phase (
        .clk        (clk),
        .rst        (rst),
        .en_i       (bits_en),
        .arm_i      (arm),
        .toggled_i  (ev.toggled),
        .mid_hit_o  (mid_hit),
        .mid_miss_o (mid_miss)
    );

    bphs_frame_ctl #(.WORD_W(WORD_W), .PRE_RUNS(PRE_RUNS)) u_ctl (
        .clk        (clk),
        .rst        (rst),
        .ev_i       (ev),
        .mid_hit_i  (mid_hit),
        .mid_miss_i (mid_miss),
        .bits_en_o  (bits_en),
        .arm_o      (arm),
        .word_o     (word_o),
        .valid_o    (valid_o),
        .err_o      (err_o)
    );

endmodule

// File: rtl/bphs_rx_chk.sv
module bphs_rx_chk #(
    parameter int unsigned WORD_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic [WORD_W-1:0] word_o,
    input logic              valid_o,
    input logic              err_o
);
    p_valid_single_r2: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);

    p_err_word_hold_r8: assert property (@(posedge clk) disable iff (rst)
        err_o |=> $stable(word_o));

    p_no_valid_in_err_r8: assert property (@(posedge clk) disable iff (rst)
        err_o |-> !valid_o);

    // fault codes 1, 2, 3 (R5, R6, R7)
    p_fault_code_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(err_o) |-> (word_o == WORD_W'(1) || word_o == WORD_W'(2) || word_o == WORD_W'(3)));

endmodule

bind bphs_rx bphs_rx_chk #(.WORD_W(WORD_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .word_o  (word_o),
    .valid_o (valid_o),
    .err_o   (err_o)
);

// File: tb/bphs_rx_test.sv
`timescale 1ns/1ps
module bphs_rx_test;
    localparam int N = 8;
    localparam int H = N / 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_i = 1'b0;
    logic [9:0] word_o;
    logic       valid_o, err_o;

    int  checks = 0, errors = 0;
    int  vcount = 0;
    logic [9:0] vword = '0;
    bit  clean_exp = 1'b0, err_flagged = 1'b0, prev_valid = 1'b0, done = 1'b0;

    always #2.5 clk = ~clk;

    bphs_rx #(.PER_BIT(N), .WORD_W(10), .PRE_RUNS(8)) uut (
        .clk(clk), .rst(rst), .rx_i(rx_i),
        .word_o(word_o), .valid_o(valid_o), .err_o(err_o)
    );

    // per-clock model comparison: strobe shape and fault expectation
    always @(negedge clk) begin
        if (!rst) begin
            if (valid_o) begin
                vcount = vcount + 1;
                vword  = word_o;
            end
            if (valid_o && prev_valid) begin
                checks++; errors++;
                $display("FAIL R2 valid high two cycles act=1 exp=0");
            end
            if (clean_exp && err_o && !err_flagged) begin
                err_flagged = 1'b1;
                checks++; errors++;
                $display("FAIL R4 unexpected fault act=%0d exp=0", word_o);
            end
        end
        prev_valid = valid_o;
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic half(input logic v, input int n);
        rx_i = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b, input int h1, input int h2);
        half(!b, h1);
        half(b, h2);
    endtask

    task automatic send_ones(input int n);
        for (int k = 0; k < n; k++) send_bit(1'b1, H, H);
    endtask

    task automatic send_start(input int ones);
        send_ones(ones);
        half(1'b0, N + H);
        half(1'b1, N + H);
    endtask

    task automatic send_payload(input logic [9:0] w, input bit jit);
        for (int i = 9; i >= 0; i--) begin
            if (jit) send_bit(w[i], H, (i % 2 == 1) ? H - 1 : H + 1);
            else     send_bit(w[i], H, H);
        end
    endtask

    function automatic logic even_par(input logic [9:0] w);
        return 1'b1 ^ (^w);
    endfunction

    task automatic send_good(input logic [9:0] w, input bit jit);
        send_start(5);
        send_bit(1'b1, H, H);
        send_payload(w, jit);
        send_bit(even_par(w), H, H);
        send_bit(1'b0, H, H);
        half(1'b1, N);
        half(1'b0, 4 * N);
    endtask

    task automatic do_reset(input bit clean);
        @(negedge clk);
        rst = 1'b1;
        rx_i = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        vcount = 0;
        vword = '0;
        clean_exp = clean;
        err_flagged = 1'b0;
    endtask

    task automatic expect_good(input string tag, input logic [9:0] w);
        check({tag, " strobe count"}, vcount, 1);
        check({tag, " word"}, vword, w);
        check({tag, " no fault"}, err_o, 0);
    endtask

    task automatic expect_idle(input string tag);
        check({tag, " no strobe"}, vcount, 0);
        check({tag, " no fault"}, err_o, 0);
    endtask

    task automatic expect_fault(input string tag, input int code);
        check({tag, " fault flag"}, err_o, 1);
        check({tag, " fault code"}, word_o, code);
        check({tag, " no strobe"}, vcount, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state
        do_reset(1'b1);
        check("R9 reset err", err_o, 0);
        check("R9 reset valid", valid_o, 0);
        check("R9 reset word", word_o, 0);

        // good frames with different ones counts
        send_good(10'b0110110011, 1'b0);
        expect_good("R1 R6 six ones", 10'b0110110011);
        do_reset(1'b1);
        send_good(10'b1000000001, 1'b0);
        expect_good("R1 two ones", 10'b1000000001);
        do_reset(1'b1);
        send_good(10'b1111111111, 1'b0);
        expect_good("R1 all ones", 10'b1111111111);
        do_reset(1'b1);
        send_good(10'b1010101010, 1'b0);
        expect_good("R6 parity zero", 10'b1010101010);

        // jittered bit periods
        do_reset(1'b1);
        send_good(10'b0101011100, 1'b1);
        expect_good("R10 jitter", 10'b0101011100);

        // quiet line
        do_reset(1'b1);
        half(1'b1, 8 * N);
        half(1'b0, 8 * N);
        expect_idle("R4 steady line");

        // wide high far too long, then a good frame still works
        do_reset(1'b1);
        send_ones(5);
        half(1'b0, N + H);
        half(1'b1, 8 * N);
        half(1'b0, 4 * N);
        expect_idle("R4 long wide high");
        send_good(10'b0011100101, 1'b0);
        expect_good("R4 idle after abort", 10'b0011100101);

        // too few one-bits before the wide runs
        do_reset(1'b1);
        half(1'b0, 4 * N);
        send_start(4);
        send_bit(1'b1, H, H);
        send_payload(10'b0110110011, 1'b0);
        send_bit(1'b1, H, H);
        send_bit(1'b0, H, H);
        half(1'b1, N);
        half(1'b0, 4 * N);
        expect_idle("R3 four ones");

        // long low where the sync bit belongs
        do_reset(1'b1);
        send_start(5);
        half(1'b0, 8 * N);
        expect_idle("R4 no sync");

        // missing mid-bit edges
        do_reset(1'b0);
        send_start(5);
        send_bit(1'b1, H, H);
        half(1'b0, 8 * N);
        expect_fault("R5 first data bit", 1);

        do_reset(1'b0);
        send_start(5);
        send_bit(1'b1, H, H);
        send_bit(1'b0, H, H); send_bit(1'b1, H, H); send_bit(1'b1, H, H);
        send_bit(1'b0, H, H); send_bit(1'b1, H, H);
        half(1'b0, 8 * N);
        expect_fault("R5 mid word", 1);

        do_reset(1'b0);
        send_start(5);
        send_bit(1'b1, H, H);
        send_payload(10'b0110110011, 1'b0);
        half(1'b0, 8 * N);
        expect_fault("R5 parity bit", 1);

        do_reset(1'b0);
        send_start(5);
        send_bit(1'b1, H, H);
        send_payload(10'b0110110011, 1'b0);
        send_bit(1'b1, H, H);
        half(1'b0, 8 * N);
        expect_fault("R5 closing bit", 1);

        // wrong parity, then sticky behaviour
        do_reset(1'b0);
        send_start(5);
        send_bit(1'b1, H, H);
        send_payload(10'b0110110011, 1'b0);
        send_bit(1'b0, H, H);
        half(1'b0, 8 * N);
        expect_fault("R6 bad parity", 2);
        send_good(10'b0110110011, 1'b0);
        expect_fault("R8 sticky", 2);

        do_reset(1'b1);
        check("R9 fault cleared", err_o, 0);
        check("R9 word cleared", word_o, 0);
        send_good(10'b1100010110, 1'b0);
        expect_good("R9 after reset", 10'b1100010110);

        // closing sequence faults
        do_reset(1'b0);
        send_start(5);
        send_bit(1'b1, H, H);
        send_payload(10'b0110110011, 1'b0);
        send_bit(1'b1, H, H);
        send_bit(1'b0, H, H);
        half(1'b0, 8 * N);
        expect_fault("R7 no closing high", 3);

        do_reset(1'b0);
        send_start(5);
        send_bit(1'b1, H, H);
        send_payload(10'b0110110011, 1'b0);
        send_bit(1'b1, H, H);
        send_bit(1'b1, H, H);
        half(1'b0, 8 * N);
        expect_fault("R7 closing bit one", 3);

        do_reset(1'b0);
        send_start(5);
        send_bit(1'b1, H, H);
        send_payload(10'b0110110011, 1'b0);
        send_bit(1'b1, H, H);
        send_bit(1'b0, H, H);
        half(1'b1, H);
        half(1'b0, 8 * N);
        expect_fault("R7 short closing high", 3);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule